// File: doc/BRIEF.md
# Programmable-Priority Interrupt Vector Controller

This block gathers thirteen level-sensitive interrupt lines, numbered 1 to 13, and presents one request to a processor. The request is a 3-bit interrupt level and an 8-bit vector number. Each line has an 8-bit control byte. Bits 4:0 of that byte form a combined code: bits 4:2 give the interrupt level, and bits 1:0 rank the source within that level. Bit 7 selects autovectoring.

A shared mask register hides pending lines. The controller registers the lines, drops the masked ones and picks the unmasked pending source with the largest code. From the winner it forms the level and the vector. The vector is either an autovector, or a value taken from one of three programmable vector bytes, or a fixed default.

Software reaches the registers through a simple synchronous write port and a combinational read port. A write takes effect on the clock edge where `wr_en_i` is high.

Register addresses:

| Address | Register |
|---|---|
| 1 to 13 | Control byte of the source with that number |
| 16 | Mask |
| 17 | Pending, read-only |
| 18 | Watchdog vector |
| 19 | Vector of source 12 |
| 20 | Vector of source 13 |

The processor acknowledge cycle and the peripherals themselves lie outside the block.

Top module: `irq_prio_ctrl`

## Requirements
- R1: The pending bit of source n is the value of line n sampled on the previous clock edge. It reads back at address 17 with source n in data bit n and bit 0 reading 0.
- R2: A write to address 17 leaves the pending register unchanged.
- R3: The mask register at address 16 holds one bit per source in data bit n, and 1 masks the source. After reset it reads 0x3FFE, so every source is masked.
- R4: After reset, the control bytes at addresses 1 to 13 read 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18, 0x1C, 0x1C, 0x80, 0x80, 0x80, 0x00 and 0x00.
- R5: Among unmasked pending sources, the one with the largest control bits 4:0 wins.
- R6: When two sources have equal codes, the lower-numbered source wins.
- R7: If the winning code is below 4, or no source is active, both the level and the vector outputs are 0.
- R8: The level output is bits 4:2 of the winner's control byte. When bit 7 of that byte is 1, the vector is 24 plus the level.
- R9: Without autovector, the vector is chosen as follows:
  - source 8 takes the watchdog vector byte at address 18, which resets to 0x0F;
  - source 12 takes the byte at address 19, and source 13 takes the byte at address 20, both resetting to 0x00;
  - every other source yields 0x0F.
- R10: The level and vector outputs are registered. They reflect the pending, mask, control and vector registers as they stood before the previous clock edge, so a line change reaches the outputs two edges later and a register write reaches them one edge after the write.
- R11: Reads of any address that is not mapped return 0, and writes to such addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines_i | input | 13 | Interrupt lines; bit n belongs to source n (index range 13:1) |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` (combinational) |
| irq_level_o | output | 3 | Presented interrupt level, 0 when no request |
| irq_vector_o | output | 8 | Presented vector number, 0 when no request |

## Verification
A wrong pending or mask bit shows on `irq_level_o` two edges after a line change, or one edge after a mask write. It can also be read directly at addresses 17 and 16. A corrupted control or vector byte appears one edge after the write, as the wrong level or vector of the source that then wins. Because a reference model is compared on every cycle, a divergence is reported within one clock of the first visible effect. Ties, sub-threshold codes and each vector route are driven deliberately so that the fault cannot stay hidden behind another source.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NSRC      = 13,
  parameter int AW        = 5,
  parameter int DW        = 16,
  parameter int WDOG_SRC  = 8,
  parameter int VA_SRC    = 12,
  parameter int VB_SRC    = 13,
  parameter int AUTO_BASE = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC:1]   irq_lines_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic [2:0]      irq_level_o,
  output logic [7:0]      irq_vector_o
);
  localparam int IW = $clog2(NSRC + 1);
  localparam logic [AW-1:0] A_MASK = AW'(16);
  localparam logic [AW-1:0] A_PEND = AW'(17);
  localparam logic [AW-1:0] A_WDV  = AW'(18);
  localparam logic [AW-1:0] A_VA   = AW'(19);
  localparam logic [AW-1:0] A_VB   = AW'(20);
  localparam logic [AW-1:0] A_LAST = AW'(NSRC);
  localparam logic [7:0]    DEF_VEC = 8'h0F;

  function automatic logic [7:0] ctrl_rst(int n);
    if (n <= 7)       return 8'(4 * n);
    else if (n == 8)  return 8'h1C;
    else if (n <= 11) return 8'h80;
    else              return 8'h00;
  endfunction

  logic [NSRC:1] pend_q, mask_q;
  logic [7:0]    ctrl_q [1:NSRC];
  logic [7:0]    wdv_q, va_q, vb_q;
  logic [2:0]    lvl_q;
  logic [7:0]    vec_q;

  wire ctrl_hit = (addr_i != '0) && (addr_i <= A_LAST);
  wire unused_wbits = ^{wdata_i[0], wdata_i[DW-1:NSRC+1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '1;
      wdv_q  <= DEF_VEC;
      va_q   <= '0;
      vb_q   <= '0;
      for (int n = 1; n <= NSRC; n++) ctrl_q[n] <= ctrl_rst(n);
    end else begin
      pend_q <= irq_lines_i;
      if (wr_en_i) begin
        if (ctrl_hit)           ctrl_q[addr_i] <= wdata_i[7:0];
        if (addr_i == A_MASK)   mask_q <= wdata_i[NSRC:1];
        if (addr_i == A_WDV)    wdv_q  <= wdata_i[7:0];
        if (addr_i == A_VA)     va_q   <= wdata_i[7:0];
        if (addr_i == A_VB)     vb_q   <= wdata_i[7:0];
      end
    end
  end

  logic [NSRC:1] act;
  logic [4:0]    best;
  logic [IW-1:0] win;
  logic [7:0]    win_ctrl;
  logic [2:0]    nxt_lvl;
  logic [7:0]    nxt_vec;

  assign act = pend_q & ~mask_q;

  always_comb begin
    best = '0;
    win = '0;
    win_ctrl = '0;
    for (int n = 1; n <= NSRC; n++) begin
      if (act[n] && ctrl_q[n][4:0] > best) begin
        best = ctrl_q[n][4:0];
        win = IW'(n);
        win_ctrl = ctrl_q[n];
      end
    end
  end

  always_comb begin
    nxt_lvl = '0;
    nxt_vec = '0;
    if (best >= 5'd4) begin
      nxt_lvl = win_ctrl[4:2];
      if (win_ctrl[7])                nxt_vec = 8'(AUTO_BASE) + {5'd0, win_ctrl[4:2]};
      else if (win == IW'(WDOG_SRC))  nxt_vec = wdv_q;
      else if (win == IW'(VA_SRC))    nxt_vec = va_q;
      else if (win == IW'(VB_SRC))    nxt_vec = vb_q;
      else                            nxt_vec = DEF_VEC;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      vec_q <= '0;
    end else begin
      lvl_q <= nxt_lvl;
      vec_q <= nxt_vec;
    end
  end

  assign irq_level_o  = lvl_q;
  assign irq_vector_o = vec_q;

  always_comb begin
    rdata_o = '0;
    if (ctrl_hit)               rdata_o = DW'(ctrl_q[addr_i]);
    else if (addr_i == A_MASK)  rdata_o = DW'({mask_q, 1'b0});
    else if (addr_i == A_PEND)  rdata_o = DW'({pend_q, 1'b0});
    else if (addr_i == A_WDV)   rdata_o = DW'(wdv_q);
    else if (addr_i == A_VA)    rdata_o = DW'(va_q);
    else if (addr_i == A_VB)    rdata_o = DW'(vb_q);
  end
endmodule

module irq_prio_ctrl_chk #(
  parameter int NSRC = 13,
  parameter int AW   = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NSRC:1] lines,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [NSRC:1] pend,
  input logic [NSRC:1] mask,
  input logic [2:0]    lvl,
  input logic [7:0]    vec
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  // R1
  pend_follow_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    pend == $past(lines));

  // R2
  pend_wr_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(17)) |=> (pend == $past(lines)));

  // R3
  all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |=> (lvl == 3'd0));

  // R7
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |=> (lvl == 3'd0 && vec == 8'd0));

  // R7
  lvl0_vec0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == 3'd0) |-> (vec == 8'd0));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NSRC(NSRC), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .lines(irq_lines_i), .wr_en(wr_en_i), .addr(addr_i),
  .pend(pend_q), .mask(mask_q), .lvl(irq_level_o), .vec(irq_vector_o)
);

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [13:1] src = '0;
  logic        wr_en = 0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [2:0]  lvl;
  logic [7:0]  vec;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_lines_i(src), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_level_o(lvl), .irq_vector_o(vec)
  );

  // reference model
  logic [13:1] m_pend, m_mask;
  int m_ctrl [1:13];
  int m_wdv, m_va, m_vb, m_lvl, m_vec;
  int rst_tab [1:13] = '{4, 8, 12, 16, 20, 24, 28, 28, 128, 128, 128, 0, 0};

  task automatic ref_eval(output int ol, output int ov);
    int best = -1, w = 0;
    for (int n = 13; n >= 1; n--)
      if (m_pend[n] && !m_mask[n] && (m_ctrl[n] % 32) >= best) begin
        best = m_ctrl[n] % 32;
        w = n;
      end
    ol = 0; ov = 0;
    if (w != 0 && best >= 4) begin
      ol = best / 4;
      if (m_ctrl[w] >= 128) ov = 24 + ol;
      else if (w == 8)      ov = m_wdv;
      else if (w == 12)     ov = m_va;
      else if (w == 13)     ov = m_vb;
      else                  ov = 15;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = '0; m_mask = '1; m_wdv = 15; m_va = 0; m_vb = 0; m_lvl = 0; m_vec = 0;
      for (int n = 1; n <= 13; n++) m_ctrl[n] = rst_tab[n];
    end else begin
      ref_eval(m_lvl, m_vec);
      if (wr_en) begin
        if (addr >= 1 && addr <= 13) m_ctrl[addr] = int'(wdata[7:0]);
        if (addr == 16) m_mask = wdata[13:1];
        if (addr == 18) m_wdv = int'(wdata[7:0]);
        if (addr == 19) m_va = int'(wdata[7:0]);
        if (addr == 20) m_vb = int'(wdata[7:0]);
      end
      m_pend = src;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model (R5 R6 R7 R8 R9 R10)
  always @(negedge clk)
    if (rst_n && !done) begin
      chk("R10 model level", int'(lvl), m_lvl);
      chk("R8 model vector", int'(vec), m_vec);
    end

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1; addr = 5'(a); wdata = 16'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(string tag, int a, int exp);
    @(negedge clk);
    addr = 5'(a);
    #1 chk(tag, int'(rdata), exp);
  endtask

  task automatic settle;
    repeat (2) @(negedge clk);
  endtask

  task automatic out_chk(string tag, int el, int ev);
    chk({tag, " level"}, int'(lvl), el);
    chk({tag, " vector"}, int'(vec), ev);
  endtask

  task automatic finish_run;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    out_chk("reset", 0, 0);
    rd("R3 mask reset", 16, 16'h3FFE);
    for (int n = 1; n <= 13; n++) rd("R4 control reset", n, rst_tab[n]);
    rd("R9 watchdog vector reset", 18, 8'h0F);
    rd("R9 vector 12 reset", 19, 0);
    rd("R11 unmapped 0", 0, 0);
    rd("R11 unmapped 31", 31, 0);
    wr(25, 16'hFFFF);
    rd("R11 write ignored", 25, 0);

    src = '1; settle;
    out_chk("R3 all masked", 0, 0);
    rd("R1 pending readback", 17, 16'h3FFE);
    wr(17, 0);
    rd("R2 pending write ignored", 17, 16'h3FFE);

    src = '0; wr(16, 0); settle;
    out_chk("R7 nothing pending", 0, 0);
    src[3] = 1; settle;
    out_chk("R9 default vector src3", 3, 8'h0F);

    src = '0; src[2] = 1; src[4] = 1; settle;
    out_chk("R5 larger code wins", 4, 8'h0F);

    wr(18, 8'h40);
    src = '0; src[7] = 1; src[8] = 1; settle;
    out_chk("R6 tie lower source", 7, 8'h0F);
    src[7] = 0; settle;
    out_chk("R9 watchdog vector src8", 7, 8'h40);

    src = '0; src[9] = 1; settle;
    out_chk("R7 code zero", 0, 0);
    wr(9, 8'h83); settle;
    out_chk("R7 code three", 0, 0);
    wr(9, 8'h94); settle;
    out_chk("R8 autovector", 5, 29);

    wr(19, 8'h55); wr(20, 8'h66); wr(12, 8'h18); wr(13, 8'h19);
    src = '0; src[12] = 1; src[13] = 1; settle;
    out_chk("R9 vector src13", 6, 8'h66);
    wr(16, 16'h2000); settle;
    out_chk("R3 mask src13", 6, 8'h55);
    rd("R3 mask readback", 16, 16'h2000);

    wr(16, 0); src = '0; settle;
    @(negedge clk); src[4] = 1;
    @(negedge clk);
    out_chk("R10 one edge after line", 0, 0);
    @(negedge clk);
    out_chk("R10 two edges after line", 4, 8'h0F);
    wr(4, 8'h0C);
    out_chk("R10 write edge", 4, 8'h0F);
    @(negedge clk);
    out_chk("R10 edge after write", 3, 8'h0F);

    settle;
    finish_run;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run;
    end
  end
endmodule